// File: doc/BRIEF.md
# Parallel Pitch-Lag Correlation Search

This block picks the long-term prediction lag for one 40-sample speech subframe. The caller writes the current block and the 120 samples that came before it into two internal stores, then pulses a start input. The block scores every candidate lag from 40 to 120. The score for a lag is the cross-correlation between the current block and the history shifted by that lag. The block returns the lag with the highest score and the score itself, and pulses done for one cycle.

The lag range is split into equal slices, one slice per correlator lane. Every lane reads the same two stores and runs one multiply-accumulate per cycle. All lanes step through their slices in lock step. Each lane keeps only its own best score and the lag where that score occurred. Lanes are grouped under first-level nodes. Each node takes the best result among its own lane and its child lanes. A hub then takes the best result across the nodes. No result carries the number of the lane it came from. A full frame of four subframes needs four searches in sequence. Between searches the caller rewrites the history.

Top module: `pitch_lag_search`

## Requirements
- R1: A load is accepted on a clock edge where `ld_en` is 1 and the block is idle. With `ld_hist` = 0 it writes the current-block word `ld_idx` (0..39). With `ld_hist` = 1 it writes the history word `ld_idx` (0..119), where word 119 is the sample just before the current block. Any index outside these ranges changes nothing.
- R2: For each lag L from 40 to 120, the score is the sum over k = 0..39 of cur[k] × hist[120 + k − L]. The reported `lag` is always in the range 40..120.
- R3: The reported `lag` is a lag whose score is the largest. `peak` is that score as a 40-bit two's-complement value, kept at full precision for any 16-bit signed samples, including full-scale negative values.
- R4: If two or more lags share the largest score, the smallest of those lags is reported. This holds whether the tied lags are in the same lane, in different lanes of one node, or under different nodes.
- R5: The 81 lags are split into 9 lanes of 9 consecutive lags each. Lanes are grouped 3 per first-level node. The hub result is never lower than any node result.
- R6: `done` goes high for exactly one cycle, 362 clock edges after the edge that samples `start`. This is 9 lags × 40 taps, plus one node-merge cycle and one hub-merge cycle.
- R7: While a search is running, `start` and all loads are ignored. The running search completes with the original data, and the stores keep that data for the next search.
- R8: After reset, `done` is 0, `lag` is 0 and `peak` is 0.
- R9: `lag` and `peak` change only in the cycle where `done` is high. Between searches they hold their values, even while new data is being loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_en | input | 1 | Write one sample into a store |
| ld_hist | input | 1 | Store select: 0 = current block, 1 = history |
| ld_idx | input | 7 | Word index within the selected store |
| ld_data | input | 16 | Signed sample |
| start | input | 1 | Begin a search (acted on only when idle) |
| done | output | 1 | One-cycle pulse when the result is ready |
| lag | output | 7 | Selected lag |
| peak | output | 40 | Correlation at the selected lag, signed |

## Verification
The bench builds the block with its default parameters: 9 lanes of 9 lags each, grouped 3 lanes to a node. With this split a single impulse pair can place the winning lag at either end of the range or in the middle of any lane. Tied pairs can also be placed on purpose:
- lags 41 and 43, inside lane 0;
- lags 48 and 49, across the boundary between lane 0 and lane 1;
- lags 50 and 100, under different nodes;
- lags 40 and 120, at the two ends of the range.

Full-scale negative inputs and all-negative scores exercise the accumulator width and the first-lag initialisation. Pseudo-random data is checked against a direct model of the score.

// File: rtl/pitch_lag_search.sv
module pitch_lag_search #(
  parameter int SW     = 16,
  parameter int AW     = 40,
  parameter int NSUB   = 40,
  parameter int NHIST  = 120,
  parameter int LAG_LO = 40,
  parameter int LAG_HI = 120,
  parameter int NLANE  = 9,
  parameter int FAN    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic          ld_hist,
  input  logic [6:0]    ld_idx,
  input  logic [SW-1:0] ld_data,
  input  logic          start,
  output logic          done,
  output logic [6:0]    lag,
  output logic [AW-1:0] peak
);
  localparam int NLAG  = LAG_HI - LAG_LO + 1;
  localparam int LPL   = NLAG / NLANE;
  localparam int NNODE = NLANE / FAN;
  localparam int LW    = 7;
  localparam int KW    = $clog2(NSUB);
  localparam int JW    = (LPL > 1) ? $clog2(LPL) : 1;
  localparam int IW    = $clog2(NHIST);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_NODE, S_HUB} state_t;

  state_t state_q;
  logic [KW-1:0] k_q;
  logic [JW-1:0] j_q;
  logic          done_q;
  logic [LW-1:0] lag_q;
  logic signed [AW-1:0] peak_q;

  logic signed [SW-1:0] cur_q  [NSUB];
  logic signed [SW-1:0] hist_q [NHIST];

  logic signed [AW-1:0] lane_pk  [NLANE];
  logic [LW-1:0]        lane_lag [NLANE];
  logic signed [AW-1:0] node_pk  [NNODE];
  logic [LW-1:0]        node_lag [NNODE];
  logic signed [AW-1:0] n_pk  [NNODE];
  logic [LW-1:0]        n_lag [NNODE];
  logic signed [AW-1:0] hub_pk;
  logic [LW-1:0]        hub_lag;

  wire k_last = (k_q == KW'(NSUB - 1));
  wire j_last = (j_q == JW'(LPL - 1));
  wire run    = (state_q == S_RUN);

  assign done = done_q;
  assign lag  = lag_q;
  assign peak = peak_q;

  always_ff @(posedge clk) begin
    if (state_q == S_IDLE && ld_en) begin
      if (!ld_hist && int'(ld_idx) < NSUB) cur_q[ld_idx[KW-1:0]] <= ld_data;
      if (ld_hist && int'(ld_idx) < NHIST) hist_q[ld_idx[IW-1:0]] <= ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      k_q     <= '0;
      j_q     <= '0;
      done_q  <= 1'b0;
      lag_q   <= '0;
      peak_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_RUN;
          k_q     <= '0;
          j_q     <= '0;
        end
        S_RUN: begin
          if (k_last) begin
            k_q <= '0;
            if (j_last) state_q <= S_NODE;
            else        j_q <= j_q + 1'b1;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        S_NODE: state_q <= S_HUB;
        default: begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
          lag_q   <= hub_lag;
          peak_q  <= hub_pk;
        end
      endcase
    end
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LW-1:0] lag_w;
    logic [IW-1:0] hidx;
    logic signed [2*SW-1:0] prod;
    logic signed [AW-1:0] sum, acc_q, best_q;
    logic [LW-1:0] blag_q;

    assign lag_w = LW'(LAG_LO + i * LPL) + LW'(j_q);
    assign hidx  = IW'(NHIST + int'(k_q) - int'(lag_w));
    assign prod  = cur_q[k_q] * hist_q[hidx];
    assign sum   = acc_q + AW'(prod);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        acc_q  <= '0;
        best_q <= '0;
        blag_q <= '0;
      end else if (run) begin
        if (k_last) begin
          acc_q <= '0;
          if (j_q == '0 || sum > best_q) begin
            best_q <= sum;
            blag_q <= lag_w;
          end
        end else begin
          acc_q <= sum;
        end
      end
    end

    assign lane_pk[i]  = best_q;
    assign lane_lag[i] = blag_q;
  end

  always_comb begin
    for (int g = 0; g < NNODE; g++) begin
      n_pk[g]  = lane_pk[g*FAN];
      n_lag[g] = lane_lag[g*FAN];
      for (int c = 1; c < FAN; c++) begin
        if (lane_pk[g*FAN+c] > n_pk[g]) begin
          n_pk[g]  = lane_pk[g*FAN+c];
          n_lag[g] = lane_lag[g*FAN+c];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NNODE; g++) begin
        node_pk[g]  <= '0;
        node_lag[g] <= '0;
      end
    end else if (state_q == S_NODE) begin
      for (int g = 0; g < NNODE; g++) begin
        node_pk[g]  <= n_pk[g];
        node_lag[g] <= n_lag[g];
      end
    end
  end

  always_comb begin
    hub_pk  = node_pk[0];
    hub_lag = node_lag[0];
    for (int g = 1; g < NNODE; g++) begin
      if (node_pk[g] > hub_pk) begin
        hub_pk  = node_pk[g];
        hub_lag = node_lag[g];
      end
    end
  end

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r2_lag_range: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (int'(lag_q) >= LAG_LO && int'(lag_q) <= LAG_HI));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lag_q) || !$stable(peak_q)) |-> done_q);

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> state_q != S_IDLE);

  a_r2_tap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(k_q) < NSUB);

  for (genvar g = 0; g < NNODE; g++) begin : g_chk
    a_r5_hub_ge_node: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> peak_q >= node_pk[g]);
  end
endmodule

// File: tb/tb_pitch_lag_search.sv
module tb_pitch_lag_search;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0, ld_hist = 1'b0, start = 1'b0;
  logic [6:0] ld_idx = '0;
  logic [15:0] ld_data = '0;
  logic done;
  logic [6:0] lag;
  logic [39:0] peak;

  always #4 clk = ~clk;

  pitch_lag_search dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_hist(ld_hist),
    .ld_idx(ld_idx), .ld_data(ld_data), .start(start),
    .done(done), .lag(lag), .peak(peak)
  );

  int n_chk = 0, n_bad = 0;
  int cur_m [40];
  int hist_m [120];

  // kind, p0, p1, p2, expected lag (-1: model only)
  localparam int NV = 12;
  localparam int TBL [NV][5] = '{
    '{1, 39, 119, 0, 40},
    '{1, 0, 0, 0, 120},
    '{1, 20, 63, 0, 77},
    '{0, 0, 0, 0, 40},
    '{2, -1, 1, 0, 40},
    '{4, 10, 50, 100, 50},
    '{4, 5, 41, 43, 41},
    '{4, 30, 48, 49, 48},
    '{2, -32768, -32768, 0, 40},
    '{3, 17, 0, 0, -1},
    '{3, 99, 0, 0, -1},
    '{4, 0, 120, 40, 40}
  };

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic h, input int idx, input int val);
    @(negedge clk);
    ld_en = 1'b1; ld_hist = h; ld_idx = 7'(idx); ld_data = 16'(val);
    @(posedge clk); #1;
    ld_en = 1'b0;
  endtask

  task automatic build(input int kind, input int a, input int b, input int c);
    int s;
    s = a;
    for (int i = 0; i < 40; i++) cur_m[i] = 0;
    for (int i = 0; i < 120; i++) hist_m[i] = 0;
    case (kind)
      1: begin cur_m[a] = 1000; hist_m[b] = 1000; end
      2: begin
        for (int i = 0; i < 40; i++) cur_m[i] = a;
        for (int i = 0; i < 120; i++) hist_m[i] = b;
      end
      3: begin
        for (int i = 0; i < 160; i++) begin
          s = (s * 1103515245 + 12345) & 32'h7fffffff;
          if (i < 40) cur_m[i] = int'($signed(16'(s >> 8)));
          else hist_m[i-40] = int'($signed(16'(s >> 8)));
        end
      end
      4: begin
        cur_m[a] = 500;
        hist_m[120 + a - b] = 500;
        hist_m[120 + a - c] = 500;
      end
      default: ;
    endcase
    for (int i = 0; i < 40; i++) load(1'b0, i, cur_m[i]);
    for (int i = 0; i < 120; i++) load(1'b1, i, hist_m[i]);
  endtask

  task automatic model(output int ml, output longint mp);
    longint sc;
    ml = 40; mp = 0;
    for (int l = 40; l <= 120; l++) begin
      sc = 0;
      for (int k = 0; k < 40; k++) sc += longint'(cur_m[k]) * longint'(hist_m[120 + k - l]);
      if (l == 40 || sc > mp) begin mp = sc; ml = l; end
    end
  endtask

  task automatic search(output int lat);
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin @(posedge clk); #1; lat++; end
    if (lat >= 2000) begin n_chk++; n_bad++; $display("FAIL watchdog: no done"); end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, ml, cnt, pulses;
    longint mp;
    logic [6:0] hl;
    logic [39:0] hp;
    repeat (3) @(posedge clk);
    #1;
    check("R8 done after reset", longint'(done), 0);
    check("R8 lag after reset", longint'(lag), 0);
    check("R8 peak after reset", longint'(peak), 0);
    @(negedge clk); rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      build(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3]);
      model(ml, mp);
      search(lat);
      check("R6 latency", lat, 362);
      check("R2 R3 lag vs model", longint'(lag), ml);
      check("R3 peak vs model", $signed(peak), mp);
      if (TBL[v][4] >= 0) check("R4 R5 lag vs table", longint'(lag), TBL[v][4]);
    end

    // R7: start and loads while busy are ignored; R1 out-of-range loads
    build(1, 20, 63, 0);
    load(1'b0, 45, 3000);
    load(1'b1, 125, 3000);
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    cnt = 0;
    while (!done && cnt < 2000) begin
      @(posedge clk); #1; cnt++;
      if (cnt == 100) begin
        @(negedge clk);
        start = 1'b1; ld_en = 1'b1; ld_hist = 1'b0; ld_idx = 7'd20; ld_data = 16'hec78;
        @(posedge clk); #1; cnt++;
        start = 1'b0; ld_en = 1'b0;
      end
    end
    check("R7 latency with start while busy", cnt, 362);
    check("R7 R1 lag unaffected", longint'(lag), 77);
    check("R7 R1 peak unaffected", $signed(peak), 1000000);
    pulses = 0;
    for (int i = 0; i < 400; i++) begin @(posedge clk); #1; if (done) pulses++; end
    check("R7 no second done", pulses, 0);
    search(lat);
    check("R7 store kept lag", longint'(lag), 77);
    check("R7 store kept peak", $signed(peak), 1000000);

    // R9: hold after done, also across loads
    hl = lag; hp = peak;
    repeat (20) @(posedge clk);
    load(1'b0, 3, 1234);
    load(1'b1, 7, -99);
    #1;
    check("R9 lag held", longint'(lag), longint'(hl));
    check("R9 peak held", longint'(peak), longint'(hp));
    check("R6 done low between searches", longint'(done), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule